// File: doc/BRIEF.md
# Sound Coprocessor Window Bus Decoder

This block sits between the main processor's bus and the resources owned by a sound coprocessor. It claims every main-processor access at address 0xA00000 or above. Accesses in the 64 KB window at 0xA00000–0xA0FFFF go to three places: shared sound RAM (8 KB, mirrored), the four ports of an FM synthesis chip, or a small sub-area that holds a one-bit bank register and a lockup trap. Accesses in the page range 0xA100xx–0xA1FFxx hold two control registers. One requests the coprocessor's bus and the other drives its reset. A read of the bus-request page returns the coprocessor's bus-acknowledge flag.

Some accesses must never complete. These are an undecoded control page, anything at 0xA20000 or above, and the trap page in the window. Such an access locks the bus: the cycle acknowledge is withheld and a sticky halted flag is set, and only reset clears it. A configuration input forces the acknowledge instead, and then the access completes harmlessly.

While the coprocessor holds its own bus, the main processor cannot reach the window. Reads there return the open-bus value, and writes are dropped. The open-bus value is the last word seen on the main bus and is supplied as an input. RAM and the FM chip are outside the block and are reached through simple combinational ports. The block has no memory of its own.

Top module: `snd_window_dec`

## Requirements
- R1: In the window (address bits [23:16] = 0xA0) with the coprocessor not holding its bus, address bits [14:13] select the target: 2'b10 selects the FM chip, 2'b11 selects the bank/trap sub-area, and 2'b00 or 2'b01 selects sound RAM. The RAM address is bits [12:0] of the access address, so the RAM repeats four times across the window.
- R2: An FM access drives the FM port number from address bits [1:0]. A write pulses the FM write enable for the cycle of the write strobe.
- R3: Data lane rules. A byte read returns its byte in rdata[7:0] with rdata[15:8] zero. A word read of RAM or FM returns the byte in both halves. A word write sends wdata[15:8] to RAM or FM, and a byte write sends wdata[7:0].
- R4: While cop_hold_i is 1, window accesses are acknowledged without reaching any target. No RAM or FM write enable is raised, the bank register keeps its value, and a read returns open bus. For open bus, a word read returns the full word and a byte read returns the byte selected as in R11.
- R5: In the sub-area, address bits [14:8] = 0x60 select the bank register. A write loads it from wdata[0] for a byte or wdata[8] for a word, at the clock edge of the write. A read anywhere in the sub-area returns all ones: 0xFFFF for a word and 0x00FF for a byte.
- R6: Page 0xA111 holds the bus-request register and page 0xA112 holds the coprocessor-reset register. A word write or an even-address byte write loads the register from wdata[8] or wdata[0] respectively. An odd-address byte write leaves the register unchanged. A read of page 0xA112 returns open bus.
- R7: A read of page 0xA111 returns cop_hold_i. A byte read places it in bit 0, with bits [7:1] taken from the open-bus byte. A word read places it in bit 8, with the other bits taken from the open-bus word.
- R8: The following accesses are lockups: window sub-area page 0x7F, a control page other than 0x11 or 0x12, and any address at 0xA20000 or above. A lockup read returns all ones and a lockup write changes nothing. A lockup withholds ack_o unless force_ack_i is 1. Addresses below 0xA00000 are not claimed: ack_o stays 0 and the block has no effect.
- R9: A lockup with force_ack_i at 0 sets halted_o at the clock edge. halted_o stays set until reset. While it is set, ack_o is 0 and writes change nothing.
- R10: After reset, bank_o, busreq_o, cop_rst_o and halted_o are all 0.
- R11: A byte read of open bus takes open_bus_i[15:8] at an even address and open_bus_i[7:0] at an odd address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 24 | Access address |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| open_bus_i | input | 16 | Last word seen on the main bus |
| cop_hold_i | input | 1 | Coprocessor holds its bus (acknowledge flag) |
| force_ack_i | input | 1 | Acknowledge lockup accesses instead of halting |
| ram_addr_o | output | 13 | Sound RAM address |
| ram_we_o | output | 1 | Sound RAM write enable |
| ram_wdata_o | output | 8 | Sound RAM write byte |
| ram_rdata_i | input | 8 | Sound RAM read byte |
| fm_port_o | output | 2 | FM chip port select |
| fm_we_o | output | 1 | FM chip write enable |
| fm_wdata_o | output | 8 | FM chip write byte |
| fm_rdata_i | input | 8 | FM chip status byte |
| bank_o | output | 1 | Bank register |
| busreq_o | output | 1 | Coprocessor bus request |
| cop_rst_o | output | 1 | Coprocessor reset control |
| halted_o | output | 1 | Sticky lockup flag |
| ack_o | output | 1 | Cycle acknowledge |
| rdata_o | output | 16 | Read data |

## Verification
The hardest state to reach is a halted bus, together with the sequences around it. The flag is set only by a lockup with the force input low. After that, every later access must look dead at the ports until reset, so each random run would end in silence after its first stray lockup. The stimulus therefore keeps the force input high for most random vectors and applies reset whenever the bench's own model shows the halted flag set. Directed sequences drive a trap-page access and an undecoded control page with the force input low. They then attempt RAM and control writes, and finally reset, checking the acknowledge, the write enables and the registers at each step.

// File: rtl/snd_window_dec.sv
module snd_window_dec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] addr_i,
  input  logic        word_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  input  logic [15:0] open_bus_i,
  input  logic        cop_hold_i,
  input  logic        force_ack_i,
  output logic [12:0] ram_addr_o,
  output logic        ram_we_o,
  output logic [7:0]  ram_wdata_o,
  input  logic [7:0]  ram_rdata_i,
  output logic [1:0]  fm_port_o,
  output logic        fm_we_o,
  output logic [7:0]  fm_wdata_o,
  input  logic [7:0]  fm_rdata_i,
  output logic        bank_o,
  output logic        busreq_o,
  output logic        cop_rst_o,
  output logic        halted_o,
  output logic        ack_o,
  output logic [15:0] rdata_o
);

  localparam logic [7:0] WIN_SEG  = 8'hA0;
  localparam logic [7:0] CTL_SEG  = 8'hA1;
  localparam logic [7:0] REQ_PAGE = 8'h11;
  localparam logic [7:0] RST_PAGE = 8'h12;
  localparam logic [6:0] BNK_PAGE = 7'h60;
  localparam logic [6:0] TRP_PAGE = 7'h7F;

  logic [7:0] seg, page;
  logic [1:0] zone;
  logic       acc, sel, in_win, in_ctl, open_win;
  logic       hit_ram, hit_fm, hit_sub, hit_bank, hit_req, hit_rst;
  logic       lock, stall, live_wr, ctl_wr, wbit;
  logic [7:0] wbyte, ob_byte;

  assign seg      = addr_i[23:16];
  assign page     = addr_i[15:8];
  assign zone     = addr_i[14:13];
  assign acc      = rd_i | wr_i;
  assign sel      = seg >= WIN_SEG;
  assign in_win   = seg == WIN_SEG;
  assign in_ctl   = seg == CTL_SEG;
  assign open_win = in_win & ~cop_hold_i;

  assign hit_ram  = open_win & ~zone[1];
  assign hit_fm   = open_win & (zone == 2'b10);
  assign hit_sub  = open_win & (zone == 2'b11);
  assign hit_bank = hit_sub & (addr_i[14:8] == BNK_PAGE);
  assign hit_req  = in_ctl & (page == REQ_PAGE);
  assign hit_rst  = in_ctl & (page == RST_PAGE);

  assign lock  = acc & ((hit_sub & (addr_i[14:8] == TRP_PAGE)) |
                        (in_ctl & ~hit_req & ~hit_rst) | (seg > CTL_SEG));
  assign stall = lock & ~force_ack_i;
  assign ack_o = sel & acc & ~halted_o & ~stall;

  assign live_wr = wr_i & ~halted_o & ~lock;
  assign ctl_wr  = live_wr & (word_i | ~addr_i[0]);
  assign wbyte   = word_i ? wdata_i[15:8] : wdata_i[7:0];
  assign wbit    = word_i ? wdata_i[8] : wdata_i[0];
  assign ob_byte = addr_i[0] ? open_bus_i[7:0] : open_bus_i[15:8];

  assign ram_addr_o  = addr_i[12:0];
  assign ram_we_o    = live_wr & hit_ram;
  assign ram_wdata_o = wbyte;
  assign fm_port_o   = addr_i[1:0];
  assign fm_we_o     = live_wr & hit_fm;
  assign fm_wdata_o  = wbyte;

  always_comb begin
    if (!rd_i || !sel)
      rdata_o = 16'h0000;
    else if (lock || hit_sub)
      rdata_o = word_i ? 16'hFFFF : 16'h00FF;
    else if (hit_ram)
      rdata_o = word_i ? {ram_rdata_i, ram_rdata_i} : {8'h00, ram_rdata_i};
    else if (hit_fm)
      rdata_o = word_i ? {fm_rdata_i, fm_rdata_i} : {8'h00, fm_rdata_i};
    else if (hit_req)
      rdata_o = word_i ? {open_bus_i[15:9], cop_hold_i, open_bus_i[7:0]}
                       : {8'h00, ob_byte[7:1], cop_hold_i};
    else
      rdata_o = word_i ? open_bus_i : {8'h00, ob_byte};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_o    <= 1'b0;
      busreq_o  <= 1'b0;
      cop_rst_o <= 1'b0;
      halted_o  <= 1'b0;
    end else begin
      if (live_wr && hit_bank) bank_o    <= wbit;
      if (ctl_wr && hit_req)   busreq_o  <= wbit;
      if (ctl_wr && hit_rst)   cop_rst_o <= wbit;
      if (stall)               halted_o  <= 1'b1;
    end
  end

  // R4
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o || fm_we_o) |-> !cop_hold_i);

  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we_o, fm_we_o}));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o);

  // R9
  halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_o) |-> $past(!force_ack_i && (rd_i || wr_i)));

  // R6
  busreq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(busreq_o) |-> $past(wr_i && !halted_o && addr_i[23:8] == 16'hA111));

  // R5
  bank_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_o) |-> $past(wr_i && !cop_hold_i && addr_i[23:16] == 8'hA0));

  // R8
  ack_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (addr_i[23:16] >= 8'hA0) && !halted_o);

endmodule

// File: tb/sim_snd_window_dec.sv
module sim_snd_window_dec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [23:0] addr = '0;
  logic word = 0, rd = 0, wr = 0, hold = 0, frc = 0;
  logic [15:0] wdata = '0, obus = '0;
  logic [12:0] ram_addr;
  logic ram_we, fm_we, bank, busreq, crst, halted, ack;
  logic [7:0] ram_wd, fm_wd, ram_rd, fm_rd;
  logic [1:0] fm_port;
  logic [15:0] rdata;

  assign ram_rd = ram_addr[7:0] ^ 8'h5A;
  assign fm_rd  = {6'h26, fm_port};

  snd_window_dec u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .word_i(word), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .open_bus_i(obus), .cop_hold_i(hold), .force_ack_i(frc),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_wdata_o(ram_wd), .ram_rdata_i(ram_rd),
    .fm_port_o(fm_port), .fm_we_o(fm_we), .fm_wdata_o(fm_wd), .fm_rdata_i(fm_rd),
    .bank_o(bank), .busreq_o(busreq), .cop_rst_o(crst), .halted_o(halted),
    .ack_o(ack), .rdata_o(rdata));

  int vecs = 0, errs = 0;
  logic m_bank = 0, m_req = 0, m_rst = 0, m_halt = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_bank = 0; m_req = 0; m_rst = 0; m_halt = 0;
  endtask

  task automatic acc(input string tag, input logic [23:0] a, input bit w, input bit r,
                     input bit wt, input logic [15:0] d, input bit h, input bit f);
    logic [7:0] hi, pg, obb, wb, eb;
    logic [1:0] z;
    logic win, ctl, openw, req, rs, lk, st, e_ack, lw, e_rw, e_fw, wbit, sub;
    logic [15:0] e_rd;
    @(negedge clk);
    addr = a; word = w; rd = r; wr = wt; wdata = d; hold = h; frc = f;
    obus = 16'($urandom);
    #2;
    hi = a[23:16]; pg = a[15:8]; z = a[14:13];
    win = hi == 8'hA0; ctl = hi == 8'hA1; openw = win & !h;
    req = ctl & pg == 8'h11; rs = ctl & pg == 8'h12;
    sub = openw & z == 2'b11;
    lk = (r | wt) & ((sub & a[14:8] == 7'h7F) | (ctl & !req & !rs) | (hi > 8'hA1));
    st = lk & !f;
    e_ack = (hi >= 8'hA0) & (r | wt) & !m_halt & !st;
    lw = wt & !m_halt & !lk;
    e_rw = lw & openw & !z[1];
    e_fw = lw & openw & z == 2'b10;
    wb = w ? d[15:8] : d[7:0];
    wbit = w ? d[8] : d[0];
    obb = a[0] ? obus[7:0] : obus[15:8];
    eb = (z == 2'b10) ? {6'h26, a[1:0]} : (a[7:0] ^ 8'h5A);
    if (!r || hi < 8'hA0) e_rd = 16'h0;
    else if (lk || sub) e_rd = w ? 16'hFFFF : 16'h00FF;
    else if (openw) e_rd = w ? {eb, eb} : {8'h00, eb};
    else if (req) e_rd = w ? {obus[15:9], h, obus[7:0]} : {8'h00, obb[7:1], h};
    else e_rd = w ? obus : {8'h00, obb};
    chk({tag, " ack"}, 16'(ack), 16'(e_ack));
    chk({tag, " rdata"}, rdata, e_rd);
    chk({tag, " ram_we"}, 16'(ram_we), 16'(e_rw));
    chk({tag, " fm_we"}, 16'(fm_we), 16'(e_fw));
    if (e_rw) begin
      chk({tag, " ram_addr"}, 16'(ram_addr), 16'(a[12:0]));
      chk({tag, " ram_wd"}, 16'(ram_wd), 16'(wb));
    end
    if (e_fw) begin
      chk({tag, " fm_port"}, 16'(fm_port), 16'(a[1:0]));
      chk({tag, " fm_wd"}, 16'(fm_wd), 16'(wb));
    end
    if (lw & sub & a[14:8] == 7'h60) m_bank = wbit;
    if (lw & (w | !a[0]) & req) m_req = wbit;
    if (lw & (w | !a[0]) & rs) m_rst = wbit;
    if (st) m_halt = 1;
    @(negedge clk);
    rd = 0; wr = 0;
    #1;
    chk({tag, " bank"}, 16'(bank), 16'(m_bank));
    chk({tag, " busreq"}, 16'(busreq), 16'(m_req));
    chk({tag, " cop_rst"}, 16'(crst), 16'(m_rst));
    chk({tag, " halted"}, 16'(halted), 16'(m_halt));
  endtask

  function automatic string cat(input logic [23:0] a, input bit h);
    if (a[23:16] < 8'hA0 || a[23:16] > 8'hA1) return "R8";
    if (a[23:16] == 8'hA1) return (a[15:8] == 8'h11) ? "R7" : (a[15:8] == 8'h12) ? "R6" : "R8";
    if (h) return "R4";
    case (a[14:13]) 2'b10: return "R2"; 2'b11: return "R5"; default: return "R1";
    endcase
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    #1;
    chk("R10 bank", 16'(bank), 16'h0);
    chk("R10 busreq", 16'(busreq), 16'h0);
    chk("R10 cop_rst", 16'(crst), 16'h0);
    chk("R10 halted", 16'(halted), 16'h0);

    acc("R1", 24'hA02345, 0, 0, 1, 16'h00C3, 0, 0);
    acc("R1", 24'hA00345, 0, 1, 0, 16'h0000, 0, 0);
    acc("R2", 24'hA04002, 0, 0, 1, 16'h0077, 0, 0);
    acc("R2", 24'hA04001, 1, 1, 0, 16'h0000, 0, 0);
    acc("R3", 24'hA01000, 1, 0, 1, 16'hBE11, 0, 0);
    acc("R3", 24'hA01010, 1, 1, 0, 16'h0000, 0, 0);
    acc("R4", 24'hA01000, 0, 0, 1, 16'h00AA, 1, 0);
    acc("R4", 24'hA06000, 0, 0, 1, 16'h0001, 1, 0);
    acc("R4", 24'hA00101, 0, 1, 0, 16'h0000, 1, 0);
    acc("R5", 24'hA06000, 0, 0, 1, 16'h0001, 0, 0);
    acc("R5", 24'hA0E000, 1, 0, 1, 16'h00FF, 0, 0);
    acc("R5", 24'hA06000, 1, 0, 1, 16'h0100, 0, 0);
    acc("R5", 24'hA06002, 1, 1, 0, 16'h0000, 0, 0);
    acc("R6", 24'hA11100, 0, 0, 1, 16'h0001, 0, 0);
    acc("R6", 24'hA11101, 0, 0, 1, 16'h0000, 0, 0);
    acc("R6", 24'hA11200, 1, 0, 1, 16'h0100, 0, 0);
    acc("R6", 24'hA11201, 0, 0, 1, 16'h0000, 0, 0);
    acc("R6", 24'hA11200, 0, 1, 0, 16'h0000, 0, 0);
    acc("R7", 24'hA11100, 0, 1, 0, 16'h0000, 1, 0);
    acc("R7", 24'hA11100, 1, 1, 0, 16'h0000, 1, 0);
    acc("R11", 24'hA11201, 0, 1, 0, 16'h0000, 0, 0);
    acc("R8", 24'h9F1234, 0, 0, 1, 16'h0011, 0, 0);
    acc("R8", 24'hA17F00, 1, 1, 0, 16'h0000, 0, 1);
    acc("R8", 24'hA30000, 0, 0, 1, 16'h0001, 0, 1);
    acc("R9", 24'hA07F00, 0, 1, 0, 16'h0000, 0, 0);
    acc("R9", 24'hA00010, 0, 0, 1, 16'h0055, 0, 1);
    acc("R9", 24'hA11100, 1, 0, 1, 16'h0000, 0, 1);
    do_reset();
    #1;
    chk("R9 halted cleared", 16'(halted), 16'h0);
    acc("R9", 24'hA15000, 0, 0, 1, 16'h0000, 0, 0);
    do_reset();

    for (int i = 0; i < 3000; i++) begin
      logic [23:0] a;
      int k;
      k = int'($urandom_range(0, 19));
      a = {8'hA0, 16'($urandom)};
      if (k >= 12 && k < 17) begin
        a[23:16] = 8'hA1;
        case ($urandom_range(0, 2))
          0: a[15:8] = 8'h11;
          1: a[15:8] = 8'h12;
          default: a[15:8] = 8'($urandom);
        endcase
      end else if (k == 17) a[23:16] = 8'($urandom_range(8'hA2, 8'hFF));
      else if (k == 18) a[23:16] = 8'($urandom_range(0, 8'h9F));
      else if (k == 19) a[14:8] = ($urandom_range(0, 1) == 0) ? 7'h60 : 7'h7F;
      if (m_halt) do_reset();
      begin
        bit r;
        bit w;
        r = $urandom_range(0, 1) == 1;
        w = $urandom_range(0, 1) == 1;
        if (w) a[0] = 1'b0;
        acc(cat(a, 0), a, w, r, !r, 16'($urandom),
            $urandom_range(0, 3) == 0, $urandom_range(0, 9) != 0);
      end
    end
    finish_run();
  end
endmodule